// File: doc/BRIEF.md
# Delegated Interrupt Priority Selector

This block decides which local interrupt a hart should take at the present moment, if it should take any. It has no state. It receives the pending and enable vectors, the machine-level and hypervisor-level delegation masks, the current privilege level, the virtualization flag and the two global interrupt-enable bits. It returns a valid flag and the index of the winning interrupt.

Each interrupt line belongs to one of three groups, chosen by its two delegation bits:

- **Machine-only lines** have their machine delegation bit clear.
- **HS lines** are machine-delegated but not hypervisor-delegated.
- **VS lines** are delegated by both masks.

Each group has its own enable, and that enable depends on the privilege level. Lines that are pending, enabled and whose group is open go on to a lowest-index pick. The trap-entry logic uses the result to decide whether to redirect the hart and which cause code to record.

Top module: `irq_deleg_select`

## Requirements
- R1: Only a line whose pending bit and enable bit are both 1 can be chosen. A line with either bit clear is never reported.
- R2: Privilege is encoded as U=0, S=1 and M=3. The machine group enable is 1 when the privilege code is below 3. It is also 1 when the privilege code is 3 and the machine global enable is 1. Otherwise it is 0.
- R3: The supervisor enable is 1 when the privilege code is 0. It is also 1 when the privilege code is 1 and the supervisor global enable is 1. For every other code it is 0.
- R4: A line whose machine delegation bit is 0 survives only when the machine group enable of R2 is 1. Its hypervisor delegation bit has no effect.
- R5: A line with machine delegation 1 and hypervisor delegation 0 survives when the virtualization flag is 1 or the supervisor enable of R3 is 1.
- R6: A line with both delegation bits 1 survives only when the virtualization flag is 1 and the supervisor enable of R3 is 1.
- R7: When several lines survive, the output index is that of the lowest-numbered one. Bit 0 has the highest priority, and the top bit can be reported.
- R8: When no line survives, the valid flag is 0 and the index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pend_i | input | NIRQ | Pending interrupt lines |
| enab_i | input | NIRQ | Per-line enable |
| mdeleg_i | input | NIRQ | Machine-level delegation mask |
| hdeleg_i | input | NIRQ | Hypervisor-level delegation mask |
| priv_i | input | 2 | Current privilege (U=0, S=1, M=3) |
| virt_i | input | 1 | Virtualization active |
| mie_i | input | 1 | Machine global interrupt enable |
| sie_i | input | 1 | Supervisor global interrupt enable |
| irq_valid_o | output | 1 | An interrupt should be taken |
| irq_idx_o | output | IDX_W | Index of the chosen line (6 bits at default) |

## Verification
The embedded immediate assertions are evaluated whenever any input changes. They check that the reported line is both pending and enabled, and that no lower-numbered line also survived. They also check that the reported line's group enable held for its delegation class, and that an empty candidate set never produces a valid output.

Some behaviour can only be shown by the bench's scenarios, because an assertion that fires only on a valid output cannot see it:

- that a line whose group is open is actually chosen rather than dropped;
- the exact privilege and enable combinations that close each group.

The bench therefore compares the outputs with an independent model across every privilege and virtualization setting, using random masks.

// File: rtl/irq_deleg_select.sv
module irq_deleg_select #(
  parameter int NIRQ = 64,
  localparam int IDX_W = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic [NIRQ-1:0]  pend_i,
  input  logic [NIRQ-1:0]  enab_i,
  input  logic [NIRQ-1:0]  mdeleg_i,
  input  logic [NIRQ-1:0]  hdeleg_i,
  input  logic [1:0]       priv_i,
  input  logic             virt_i,
  input  logic             mie_i,
  input  logic             sie_i,
  output logic             irq_valid_o,
  output logic [IDX_W-1:0] irq_idx_o
);

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  logic            m_open, s_open, hs_open, vs_open;
  logic [NIRQ-1:0] cand, grp_mask, surv;

  assign cand    = pend_i & enab_i;
  assign m_open  = (priv_i < PRIV_M) || ((priv_i == PRIV_M) && mie_i);
  assign s_open  = (priv_i == PRIV_U) || ((priv_i == PRIV_S) && sie_i);
  assign hs_open = virt_i || s_open;
  assign vs_open = virt_i && s_open;

  assign grp_mask = (~mdeleg_i & {NIRQ{m_open}})
                  | (mdeleg_i & ~hdeleg_i & {NIRQ{hs_open}})
                  | (mdeleg_i & hdeleg_i & {NIRQ{vs_open}});
  assign surv = cand & grp_mask;

  always_comb begin
    irq_valid_o = 1'b0;
    irq_idx_o   = '0;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (surv[i]) begin
        irq_valid_o = 1'b1;
        irq_idx_o   = i[IDX_W-1:0];
      end
    end
  end

  logic [NIRQ-1:0] below_mask;
  assign below_mask = ~({NIRQ{1'b1}} << irq_idx_o);

  always_comb begin
    if (cand == '0) AST_EMPTY_NO_VALID: assert (!irq_valid_o); // R8
    if (irq_valid_o) begin
      AST_WINNER_PENDING: assert (pend_i[irq_idx_o] && enab_i[irq_idx_o]); // R1
      AST_LOWEST_WINS: assert ((surv & below_mask) == '0); // R7
      if (!mdeleg_i[irq_idx_o])
        AST_MGRP_GATE: assert (priv_i != PRIV_M || mie_i); // R4
      if (mdeleg_i[irq_idx_o] && !hdeleg_i[irq_idx_o])
        AST_HSGRP_GATE: assert (virt_i || priv_i == PRIV_U || (priv_i == PRIV_S && sie_i)); // R5
      if (mdeleg_i[irq_idx_o] && hdeleg_i[irq_idx_o])
        AST_VSGRP_GATE: assert (virt_i && (priv_i == PRIV_U || (priv_i == PRIV_S && sie_i))); // R6
    end else begin
      AST_IDLE_IDX_ZERO: assert (irq_idx_o == '0); // R8
    end
  end

endmodule

// File: tb/irq_deleg_select_tb.sv
module irq_deleg_select_tb_top;
  localparam int NIRQ = 64;

  typedef struct packed {
    logic [63:0] pend, en, md, hd;
    logic [1:0]  priv;
    logic        virt, mie, sie, ev;
    logic [5:0]  ei;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [0:NV-1] = '{
    '{64'h0,     64'h0,     64'h0,     64'h0,     2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 6'd0},
    '{64'h30,    64'h20,    64'h0,     64'h0,     2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 6'd5},
    '{64'h0A,    '1,        64'h0,     64'h0,     2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 6'd0},
    '{64'h0A,    '1,        64'h0,     64'h0,     2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 6'd1},
    '{64'h22,    '1,        64'h02,    64'h0,     2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 6'd5},
    '{64'h22,    '1,        64'h02,    64'h0,     2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd1},
    '{64'h404,   '1,        64'h404,   64'h004,   2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 6'd10},
    '{64'h404,   '1,        64'h404,   64'h004,   2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd10},
    '{64'h404,   '1,        64'h404,   64'h004,   2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 6'd2},
    '{64'h8000_0000_0000_0000, '1, 64'h0, '1,     2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 6'd63},
    '{'1,        '1,        '1,        64'h0,     2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 6'd0}
  };
  localparam string VTAG [0:NV-1] = '{
    "R8 empty", "R1 pend&en", "R2 R4 M closed", "R2 R7 M open", "R3 R5 HS closed",
    "R3 R5 HS open", "R5 HS via virt", "R6 VS needs virt", "R6 VS open",
    "R7 top bit", "R5 HS closed at M"
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NIRQ-1:0] pend, enab, mdel, hdel;
  logic [1:0] priv;
  logic virt, mie, sie, vld;
  logic [5:0] idx;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  irq_deleg_select #(.NIRQ(NIRQ)) dut_i (
    .pend_i(pend), .enab_i(enab), .mdeleg_i(mdel), .hdeleg_i(hdel),
    .priv_i(priv), .virt_i(virt), .mie_i(mie), .sie_i(sie),
    .irq_valid_o(vld), .irq_idx_o(idx)
  );

  function automatic logic [6:0] model(input logic [63:0] p, e, md, hd,
                                       input logic [1:0] pr, input logic v, mi, si);
    logic men, sen, ok;
    men = (pr != 2'd3) || mi;
    sen = (pr == 2'd0) || (pr == 2'd1 && si);
    for (int i = 0; i < 64; i++) begin
      if (!md[i]) ok = men;
      else if (!hd[i]) ok = v || sen;
      else ok = v && sen;
      if (p[i] && e[i] && ok) return {1'b1, i[5:0]};
    end
    return 7'd0;
  endfunction

  task automatic chk(input string req, input logic ev, input logic [5:0] ei);
    checks++;
    if (vld !== ev || idx !== ei) begin
      errors++;
      $display("FAIL %s: got valid=%0b idx=%0d expected valid=%0b idx=%0d",
               req, vld, idx, ev, ei);
    end
  endtask

  task automatic apply(input logic [63:0] p, e, md, hd, input logic [1:0] pr,
                       input logic v, mi, si);
    @(posedge clk);
    pend = p; enab = e; mdel = md; hdel = hd; priv = pr; virt = v; mie = mi; sie = si;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [6:0] m;
    logic [1:0] pr;
    logic [63:0] p, e, md, hd;
    pend = '0; enab = '0; mdel = '0; hdel = '0; priv = 2'd3; virt = 0; mie = 0; sie = 0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 idle after reset", 1'b0, 6'd0);

    for (int k = 0; k < NV; k++) begin
      apply(VECS[k].pend, VECS[k].en, VECS[k].md, VECS[k].hd,
            VECS[k].priv, VECS[k].virt, VECS[k].mie, VECS[k].sie);
      chk(VTAG[k], VECS[k].ev, VECS[k].ei);
    end

    apply(64'h1, 64'h1, 64'h0, '1, 2'd0, 1'b0, 1'b0, 1'b0);
    chk("R4 hdeleg ignored when not M-delegated", 1'b1, 6'd0);

    apply('1, 64'h0, 64'h0, 64'h0, 2'd0, 1'b1, 1'b1, 1'b1);
    chk("R1 all disabled", 1'b0, 6'd0);

    for (int c = 0; c < 24; c++) begin
      pr = (c % 3 == 2) ? 2'd3 : 2'(c % 3);
      for (int r = 0; r < 20; r++) begin
        p  = {$urandom, $urandom};
        e  = {$urandom, $urandom};
        md = {$urandom, $urandom};
        hd = {$urandom, $urandom};
        if (r % 4 == 0) p = p & {$urandom, $urandom} & {$urandom, $urandom};
        apply(p, e, md, hd, pr, c[2], c[3], c[4]);
        m = model(p, e, md, hd, pr, c[2], c[3], c[4]);
        chk("R2 R3 R5 R6 R7 random", m[6], m[5:0]);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule